// File: doc/BRIEF.md
# Ingress Word Parity Checker Filter

This block sits on the receive side of a switch adapter, between a protocol engine and the queues that feed two switch planes. It takes a stream of 32-bit words, each with its own parity bit. A start strobe marks the first word of every fixed-length packet. Every word is checked for parity as it arrives, and the packet is collected in a local buffer. The packet is released only after its last word has been checked. The block therefore decides once, for the whole packet, whether to release it or throw it away.

A released packet is presented to the X and Y plane outputs at the same time, word for word. A word advances only when both planes take it. While a packet drains, the input is held off with backpressure. Configuration inputs select the parity sense, choose whether packets that carried a parity error are discarded, and enable error reporting (a pulse plus a saturating counter). Packets flagged as idle in their first word are always absorbed. A start strobe that arrives before a packet is complete aborts that packet and raises a framing-error pulse.

Top module: `ingress_parity_filter`

## Requirements
- R1: A word passes parity when the XOR of its 32 data bits and its parity bit is 0 with `cfg_odd_parity`=0, or 1 with `cfg_odd_parity`=1; any other word is a parity error.
- R2: With `cfg_report_en`=1, each accepted word in error raises `err_report` for one cycle, in the cycle after the word is accepted, and `err_count` rises by one (saturating). With `cfg_report_en`=0, neither of them changes.
- R3: A packet is `PKT_WORDS` (default 16) accepted words, the first one carrying `in_sop`=1. Its words appear at the outputs only after the last word is accepted, in arrival order, with `*_sop` on the first output word and `*_eop` on the last.
- R4: The X and Y outputs always show the same valid, data, sop and eop. An output word is held stable and consumed only in a cycle where both `x_ready` and `y_ready` are 1.
- R5: With `cfg_drop_bad`=1 (sampled when the last word is accepted), a packet that contained any parity error produces no output. With `cfg_drop_bad`=0, it is forwarded unchanged.
- R6: A packet whose first word has bit 31 (the idle flag in the qualifier byte) set is discarded whatever its parity.
- R7: A word with `in_sop`=1 that arrives while a packet is incomplete discards the partial packet and pulses `frame_err` in the next cycle. That word starts the new packet.
- R8: `in_ready` is 0 from the acceptance of a forwarded packet's last word until its last output word is consumed. Words without `in_sop` that arrive outside a packet are ignored.
- R9: After reset, `in_ready`=1, `x_valid`=`y_valid`=0, `err_report`=0, `frame_err`=0 and `err_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_odd_parity | input | 1 | 1 selects odd parity |
| cfg_drop_bad | input | 1 | 1 discards packets that had a parity error |
| cfg_report_en | input | 1 | 1 enables the error pulse and counter |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | First word of a packet |
| in_data | input | 32 | Input word |
| in_parity | input | 1 | Parity bit of the input word |
| in_ready | output | 1 | Block accepts a word this cycle |
| x_valid | output | 1 | Plane X word valid |
| x_ready | input | 1 | Plane X takes a word |
| x_data | output | 32 | Plane X word |
| x_sop | output | 1 | Plane X first word |
| x_eop | output | 1 | Plane X last word |
| y_valid | output | 1 | Plane Y word valid |
| y_ready | input | 1 | Plane Y takes a word |
| y_data | output | 32 | Plane Y word |
| y_sop | output | 1 | Plane Y first word |
| y_eop | output | 1 | Plane Y last word |
| err_report | output | 1 | One-cycle parity error pulse |
| err_count | output | 16 | Saturating parity error count |
| frame_err | output | 1 | One-cycle pulse on an aborted packet |

## Verification
Two functions can fall in the same cycle: an early start strobe that aborts a partial packet, and a parity error on that same word. The bench provokes this by stopping a packet after five words and then starting a new packet whose first word carries a flipped parity bit, with discard enabled. The result is judged by three things: a framing pulse must appear, the error count must rise by one, and neither the partial packet nor the new corrupted one may reach the planes. A clean packet follows and must come through intact.

// File: rtl/ipf_pkg.sv
// Package: shared types for the ingress parity filter.
// Assumes: nothing beyond IEEE 1800-2017.
package ipf_pkg;
    // Controller phase: gathering input words or draining to the planes.
    typedef enum logic [0:0] {
        PH_GATHER = 1'b0,
        PH_DRAIN  = 1'b1
    } ipf_phase_e;
endpackage

// File: rtl/ipf_parity_chk.sv
// Module: ipf_parity_chk
// Checks each word for parity. When reporting is enabled, it emits a
// registered error pulse and keeps a saturating count of errors.
// Assumes: word_fire marks a word actually taken by the block.
module ipf_parity_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_fire,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_par,
    input  logic              odd_mode,
    input  logic              report_en,
    output logic              word_bad,
    output logic              err_pulse,
    output logic [CNT_W-1:0]  err_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Combine all data bits with the parity bit and compare against the sense.
    always_comb begin
        word_bad = ((^word_data) ^ word_par) != odd_mode;
    end

    // Register the report pulse and advance the saturating counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_cnt   <= '0;
        end else begin
            err_pulse <= word_fire && word_bad && report_en;
            if (word_fire && word_bad && report_en && err_cnt != CNT_MAX) begin
                err_cnt <= err_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipf_pkt_buffer.sv
// Module: ipf_pkt_buffer
// Holds one packet: one synchronous write port and one combinational
// read port.
// Assumes: writes and reads never target the buffer in the same phase.
module ipf_pkt_buffer #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] store [DEPTH];

    // Capture an accepted word at its slot in the packet.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    // Present the word that is currently being drained.
    always_comb begin
        rd_data = store[rd_idx];
    end
endmodule

// File: rtl/ipf_frame_ctrl.sv
// Module: ipf_frame_ctrl
// Tracks packet framing, accumulates the error and idle status of each
// packet, and decides whether to drain or discard it once the last word
// is in. It then sequences the drain to both planes.
// Assumes: out_ready is the AND of both plane readies.
module ipf_frame_ctrl
    import ipf_pkg::*;
#(
    parameter int PKT_WORDS = 16,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_idle,
    input  logic             word_bad,
    input  logic             drop_bad,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             word_fire,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic             out_valid,
    output logic             out_sop,
    output logic             out_eop,
    output logic             frame_err
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

    ipf_phase_e       phase;
    logic             in_pkt;
    logic [IDX_W-1:0] fill_cnt;
    logic             pkt_bad;
    logic             pkt_idle;
    logic             take_word;
    logic             last_word;
    logic             bad_acc;
    logic             idle_acc;
    logic             keep_pkt;

    // Work out the handshake and the per-word decisions for this cycle.
    always_comb begin
        in_ready  = (phase == PH_GATHER);
        word_fire = in_valid && in_ready;
        take_word = word_fire && (in_sop || in_pkt);
        wr_en     = take_word;
        wr_idx    = in_sop ? '0 : fill_cnt;
        last_word = take_word && (wr_idx == LAST_IDX);
        bad_acc   = in_sop ? word_bad : (pkt_bad || word_bad);
        idle_acc  = in_sop ? in_idle : pkt_idle;
        keep_pkt  = !idle_acc && !(bad_acc && drop_bad);
        out_valid = (phase == PH_DRAIN);
        out_sop   = out_valid && (rd_idx == '0);
        out_eop   = out_valid && (rd_idx == LAST_IDX);
    end

    // Advance the gather and drain phases and their word indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_GATHER;
            in_pkt    <= 1'b0;
            fill_cnt  <= '0;
            pkt_bad   <= 1'b0;
            pkt_idle  <= 1'b0;
            rd_idx    <= '0;
            frame_err <= 1'b0;
        end else begin
            frame_err <= word_fire && in_sop && in_pkt;
            if (phase == PH_GATHER) begin
                if (take_word) begin
                    if (last_word) begin
                        in_pkt   <= 1'b0;
                        fill_cnt <= '0;
                        rd_idx   <= '0;
                        if (keep_pkt) begin
                            phase <= PH_DRAIN;
                        end
                    end else begin
                        in_pkt   <= 1'b1;
                        fill_cnt <= wr_idx + 1'b1;
                        pkt_bad  <= bad_acc;
                        pkt_idle <= idle_acc;
                    end
                end
            end else if (out_ready) begin
                if (rd_idx == LAST_IDX) begin
                    phase  <= PH_GATHER;
                    rd_idx <= '0;
                end else begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ingress_parity_filter.sv
// Module: ingress_parity_filter (top)
// Parity-checks incoming words, buffers each fixed-length packet whole,
// and forwards accepted packets to the X and Y planes in lockstep.
// Assumes: synchronous active-low reset, one clock domain.
module ingress_parity_filter #(
    parameter int DATA_W    = 32,
    parameter int PKT_WORDS = 16,
    parameter int CNT_W     = 16,
    parameter int IDLE_BIT  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_odd_parity,
    input  logic              cfg_drop_bad,
    input  logic              cfg_report_en,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_parity,
    output logic              in_ready,
    output logic              x_valid,
    input  logic              x_ready,
    output logic [DATA_W-1:0] x_data,
    output logic              x_sop,
    output logic              x_eop,
    output logic              y_valid,
    input  logic              y_ready,
    output logic [DATA_W-1:0] y_data,
    output logic              y_sop,
    output logic              y_eop,
    output logic              err_report,
    output logic [CNT_W-1:0]  err_count,
    output logic              frame_err
);
    localparam int IDX_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;

    logic              word_bad;
    logic              word_fire;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              out_valid;
    logic              out_sop;
    logic              out_eop;
    logic              both_ready;

    // Both planes must take a word before the drain moves on.
    always_comb begin
        both_ready = x_ready && y_ready;
    end

    ipf_parity_chk #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_fire (word_fire),
        .word_data (in_data),
        .word_par  (in_parity),
        .odd_mode  (cfg_odd_parity),
        .report_en (cfg_report_en),
        .word_bad  (word_bad),
        .err_pulse (err_report),
        .err_cnt   (err_count)
    );

    ipf_frame_ctrl #(
        .PKT_WORDS (PKT_WORDS),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_idle   (in_data[IDLE_BIT]),
        .word_bad  (word_bad),
        .drop_bad  (cfg_drop_bad),
        .out_ready (both_ready),
        .in_ready  (in_ready),
        .word_fire (word_fire),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .frame_err (frame_err)
    );

    ipf_pkt_buffer #(
        .DATA_W (DATA_W),
        .DEPTH  (PKT_WORDS),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (in_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Fan the drained word out to both planes.
    always_comb begin
        x_valid = out_valid;
        x_data  = rd_data;
        x_sop   = out_sop;
        x_eop   = out_eop;
        y_valid = out_valid;
        y_data  = rd_data;
        y_sop   = out_sop;
        y_eop   = out_eop;
    end
endmodule

// File: rtl/ipf_checker.sv
// Module: ipf_checker
// Temporal properties of the ingress parity filter, bound to the top.
// Assumes: PKT_WORDS > 1, so a first word is never also a last word.
module ipf_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_report_en,
    input logic              in_ready,
    input logic              x_valid,
    input logic              x_ready,
    input logic [DATA_W-1:0] x_data,
    input logic              x_sop,
    input logic              x_eop,
    input logic              y_valid,
    input logic              y_ready,
    input logic [DATA_W-1:0] y_data,
    input logic              y_sop,
    input logic              y_eop,
    input logic              err_report,
    input logic [CNT_W-1:0]  err_count,
    input logic              frame_err
);
    AST_PLANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        x_valid == y_valid && (!x_valid || (x_data == y_data && x_sop == y_sop && x_eop == y_eop))); // R4
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && !(x_ready && y_ready)) |=> (x_valid && $stable(x_data) && $stable(x_sop))); // R4
    AST_NO_INTAKE_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        x_valid |-> !in_ready); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1)); // R2
    AST_COUNT_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count != $past(err_count)) |-> err_report); // R2
    AST_REPORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_report_en |=> !err_report); // R2
    AST_SOP_NOT_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && x_sop) |-> !x_eop); // R3
    AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err); // R7
endmodule

bind ingress_parity_filter ipf_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_report_en (cfg_report_en),
    .in_ready      (in_ready),
    .x_valid       (x_valid),
    .x_ready       (x_ready),
    .x_data        (x_data),
    .x_sop         (x_sop),
    .x_eop         (x_eop),
    .y_valid       (y_valid),
    .y_ready       (y_ready),
    .y_data        (y_data),
    .y_sop         (y_sop),
    .y_eop         (y_eop),
    .err_report    (err_report),
    .err_count     (err_count),
    .frame_err     (frame_err)
);

// File: tb/ingress_parity_filter_tb.sv
// Scoreboard bench: the driver queues the expected output words, and the
// monitor pops and compares them as the planes consume them.
module ingress_parity_filter_tb;
    localparam int NW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_odd_parity = 1'b0;
    logic        cfg_drop_bad = 1'b1;
    logic        cfg_report_en = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_parity = 1'b0;
    logic        in_ready;
    logic        x_valid, y_valid, x_sop, y_sop, x_eop, y_eop;
    logic        x_ready = 1'b1;
    logic        y_ready = 1'b1;
    logic [31:0] x_data, y_data;
    logic        err_report, frame_err;
    logic [15:0] err_count;

    int checks = 0;
    int errors = 0;
    int exp_err = 0;
    int exp_frame = 0;
    int seen_err = 0;
    int seen_frame = 0;
    int stall_mode = 0;
    int cyc = 0;
    logic [33:0] exp_q[$];

    always #2 clk = ~clk;

    ingress_parity_filter u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_odd_parity(cfg_odd_parity),
        .cfg_drop_bad(cfg_drop_bad), .cfg_report_en(cfg_report_en),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
        .in_parity(in_parity), .in_ready(in_ready),
        .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data), .x_sop(x_sop), .x_eop(x_eop),
        .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data), .y_sop(y_sop), .y_eop(y_eop),
        .err_report(err_report), .err_count(err_count), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Plane readies change just after the edge: free or stalling per plane.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        if (stall_mode != 0) begin
            x_ready = cyc[0];
            y_ready = cyc[1] | cyc[2];
        end else begin
            x_ready = 1'b1;
            y_ready = 1'b1;
        end
    end

    // Monitor: compare the planes, pop on consumption, count pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (err_report) seen_err++;
            if (frame_err) seen_frame++;
            if (x_valid || y_valid) begin
                check(x_valid == y_valid && x_data == y_data && x_sop == y_sop && x_eop == y_eop,
                      "R4 planes", {x_valid, x_sop, x_eop, x_data}, {y_valid, y_sop, y_eop, y_data});
            end
            if (x_valid && x_ready && y_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R6/R8 unexpected word", {30'd0, x_sop, x_eop, x_data}, 64'd0);
                end else begin
                    logic [33:0] e;
                    e = exp_q.pop_front();
                    check({x_sop, x_eop, x_data} == e, "R3 word", {30'd0, x_sop, x_eop, x_data}, {30'd0, e});
                end
            end
        end
    end

    task automatic put_word(input logic [31:0] d, input logic sop, input logic flip);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid  = 1'b1;
        in_sop    = sop;
        in_data   = d;
        in_parity = (^d) ^ cfg_odd_parity ^ flip;
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Driver: send one packet, queue what the planes should carry.
    task automatic send_pkt(input logic [31:0] base, input int bad_idx, input bit idle);
        bit bad = (bad_idx >= 0);
        bit keep = !idle && !(bad && cfg_drop_bad);
        for (int i = 0; i < NW; i++) begin
            logic [31:0] w = base + 32'(i);
            if (i == 0 && idle) w[31] = 1'b1;
            put_word(w, i == 0, i == bad_idx);
            if (keep) exp_q.push_back({(i == 0), (i == NW - 1), w});
        end
        if (bad && cfg_report_en) exp_err++;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(in_ready == 1'b1 && x_valid == 1'b0 && y_valid == 1'b0, "R9 ready/valid",
              {62'd0, in_ready, x_valid}, 64'h2);
        check(err_count == 0 && err_report == 0 && frame_err == 0, "R9 error outputs",
              {46'd0, err_count, err_report, frame_err}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        send_pkt(32'h0100_0000, -1, 0); drain();     // R3 clean even parity
        send_pkt(32'h0200_0010, 7, 0); drain();      // R5 drop, R1 even error
        cfg_drop_bad = 1'b0;
        send_pkt(32'h0300_0020, 3, 0); drain();      // R5 forwarded with error
        cfg_drop_bad = 1'b1;
        cfg_odd_parity = 1'b1;
        send_pkt(32'h0400_0030, -1, 0); drain();     // R1 odd clean
        send_pkt(32'h0480_0030, 15, 0); drain();     // R1 odd error on last word
        cfg_odd_parity = 1'b0;
        send_pkt(32'h0500_0040, -1, 1); drain();     // R6 idle absorbed
        cfg_report_en = 1'b0;
        cfg_drop_bad = 1'b0;
        send_pkt(32'h0600_0050, 2, 0); drain();      // R2 unreported error
        cfg_report_en = 1'b1;
        cfg_drop_bad = 1'b1;
        // R7: abort after five words, new packet carries an error on its sop word
        for (int i = 0; i < 5; i++) put_word(32'h0700_0000 + 32'(i), i == 0, 1'b0);
        exp_frame++;
        send_pkt(32'h0800_0060, 0, 0);
        send_pkt(32'h0900_0070, -1, 0); drain();     // R7 recovery
        // R8: stray words with no packet open are ignored
        for (int i = 0; i < 3; i++) put_word(32'h0A00_0000 + 32'(i), 1'b0, 1'b0);
        send_pkt(32'h0B00_0080, -1, 0); drain();
        // R4: plane stalls during drain
        stall_mode = 1;
        send_pkt(32'h0C00_0090, -1, 0);
        send_pkt(32'h0D00_00A0, -1, 0); drain();
        stall_mode = 0;
        repeat (4) @(negedge clk);

        check(exp_q.size() == 0, "R3 all words delivered", 64'(exp_q.size()), 64'd0);
        check(int'(err_count) == exp_err, "R2 err_count", 64'(err_count), 64'(exp_err));
        check(seen_err == exp_err, "R2 err_report pulses", 64'(seen_err), 64'(exp_err));
        check(seen_frame == exp_frame, "R7 frame_err pulses", 64'(seen_frame), 64'(exp_frame));
        check(in_ready == 1'b1 && x_valid == 1'b0, "R8 idle after drain", {62'd0, in_ready, x_valid}, 64'h2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule